// File: doc/BRIEF.md
# SDRAM Controller Configuration Write Guard

This block sits on the register write path of an SDRAM controller and decides, one write at a time, whether the write may land. Each configuration register has its own permission rule. A rule looks at the controller's live operating modes: access enable, auto-refresh, self-refresh, power-down and deep-power-down. Some rules also look at how far the initialization sequence has progressed. The guard holds shadow copies of the mode bits and of the address, timing and initialization registers, and it commits only the writes its rules allow. Because the shadow bits change only through accepted writes, each write changes the permission of the writes that follow it.

Each rejected write leaves every register untouched. It raises a sticky error flag and records the index of the register that was refused. Software reads the registers back through a combinational read port and clears the flag by writing 1 to it. A write that is accepted shows `wr_ok` high in the same cycle and takes effect on the next rising clock edge.

Top module: `sdram_cfg_guard`

## Requirements
- R1: Register 0 bit 0 is the access enable and register 2 bit 0 is the auto-refresh enable. Self-refresh (register 1), power-down (register 3) and deep-power-down (register 4) each have two alternative enable bits in bits [1:0], and a mode counts as on when either bit is 1. Registers 0 and 11 accept a write in every state.
- R2: Register 1 (self-refresh) accepts a write only when access is off, auto-refresh is on, and both power-down and deep-power-down are off.
- R3: Register 2 (auto-refresh) accepts a write only when both self-refresh and power-down are off.
- R4: Register 3 (power-down) accepts a write only when access is off, auto-refresh is on, and both self-refresh and deep-power-down are off. Self-refresh and power-down are therefore never on together.
- R5: Register 4 (deep-power-down) accepts a write only when access, auto-refresh, self-refresh and power-down are all off.
- R6: Registers 5 and 6 (area 0 and area 1 address setup) accept a write only when access, auto-refresh, self-refresh, power-down and deep-power-down are all off.
- R7: Registers 7 and 8 (area 0 and area 1 timing) accept a write while self-refresh is on, or when self-refresh, auto-refresh and access are all off.
- R8: Register 9 (first initialization register) accepts a write only while initialization has not started. An accepted write with bit 0 = 1 marks initialization as started.
- R9: Register 10 (second initialization register) accepts a write only while its window is open. The window opens at reset. An accepted write that turns deep-power-down on closes it. The exit from deep-power-down (an accepted write to register 4 that turns the mode from on to off) reopens it and clears the started flag.
- R10: A rejected write, including one to an undefined index (12 to 15), drives `wr_ok` low in its cycle and changes no register. From the next cycle on, `err_flag` is 1 and `err_idx` holds the refused index.
- R11: An accepted write to register 11 with bit 0 = 1 clears `err_flag` from the next cycle. Register 11 reads back the flag in bit 0 and the index in bits [7:4].
- R12: After reset every register reads 0. All modes are off, initialization has not started, the second-register window is open and `err_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request this cycle |
| wr_idx | input | 4 | Register index of the write |
| wr_data | input | 32 | Write data |
| wr_ok | output | 1 | Write accepted (same cycle as the request) |
| rd_idx | input | 4 | Register index to read |
| rd_data | output | 32 | Combinational readback of `rd_idx` |
| err_flag | output | 1 | Sticky refused-write flag |
| err_idx | output | 4 | Index of the most recently refused write |
| acc_on | output | 1 | Access enabled |
| aref_on | output | 1 | Auto-refresh enabled |
| sref_on | output | 1 | Self-refresh on (either bit) |
| pwd_on | output | 1 | Power-down on (either bit) |
| dpd_on | output | 1 | Deep-power-down on (either bit) |
| init_started | output | 1 | Initialization has been launched |
| init1_open | output | 1 | Second initialization register may be written |

## Verification
The assertions check several properties on every cycle. Self-refresh and power-down are never on together. Mode shadows and stored registers hold steady through any cycle without an accepted write. Each refusal is logged with its index on the following cycle. The error clear takes effect. Leaving deep-power-down reopens the initialization window and clears the started flag. Only the bench scenarios can show that each rule refuses and admits the right writes in sequence. They also show that a refused write with different data leaves the stored value intact, that the alternative enable bits count, and that the initialization window closes and reopens around deep-power-down.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
    parameter int SDG_NAREA  = 2;
    parameter int SDG_DATA_W = 32;

    localparam int IX_ACC   = 0;
    localparam int IX_SREF  = 1;
    localparam int IX_AREF  = 2;
    localparam int IX_PWD   = 3;
    localparam int IX_DPD   = 4;
    localparam int IX_ADDR0 = 5;
    localparam int IX_TIM0  = IX_ADDR0 + SDG_NAREA;
    localparam int IX_INIT0 = IX_TIM0 + SDG_NAREA;
    localparam int IX_INIT1 = IX_INIT0 + 1;
    localparam int IX_ERR   = IX_INIT1 + 1;
    localparam int N_REGS   = IX_ERR + 1;
    localparam int SDG_IDX_W = $clog2(N_REGS);

    typedef struct packed {
        logic       acc;
        logic       aref;
        logic [1:0] sref;
        logic [1:0] pwd;
        logic [1:0] dpd;
        logic       init_started;
        logic       init1_open;
    } mode_t;
endpackage

// File: rtl/sdg_rules.sv
module sdg_rules
    import sdg_pkg::*;
#(
    parameter int IDX_W = SDG_IDX_W
) (
    input  logic [IDX_W-1:0] wr_idx,
    input  mode_t            mode,
    output logic             allow
);
    localparam logic [IDX_W-1:0] K_ACC   = IDX_W'(IX_ACC);
    localparam logic [IDX_W-1:0] K_SREF  = IDX_W'(IX_SREF);
    localparam logic [IDX_W-1:0] K_AREF  = IDX_W'(IX_AREF);
    localparam logic [IDX_W-1:0] K_PWD   = IDX_W'(IX_PWD);
    localparam logic [IDX_W-1:0] K_DPD   = IDX_W'(IX_DPD);
    localparam logic [IDX_W-1:0] K_ADDR0 = IDX_W'(IX_ADDR0);
    localparam logic [IDX_W-1:0] K_TIM0  = IDX_W'(IX_TIM0);
    localparam logic [IDX_W-1:0] K_INIT0 = IDX_W'(IX_INIT0);
    localparam logic [IDX_W-1:0] K_INIT1 = IDX_W'(IX_INIT1);
    localparam logic [IDX_W-1:0] K_ERR   = IDX_W'(IX_ERR);

    logic sref_on, pwd_on, dpd_on;
    logic all_quiet;

    always_comb begin
        sref_on   = |mode.sref;
        pwd_on    = |mode.pwd;
        dpd_on    = |mode.dpd;
        all_quiet = !mode.acc && !mode.aref && !sref_on && !pwd_on && !dpd_on;

        allow = 1'b0;
        if (wr_idx == K_ACC || wr_idx == K_ERR) begin
            allow = 1'b1;
        end else if (wr_idx == K_SREF) begin
            allow = !mode.acc && mode.aref && !pwd_on && !dpd_on;
        end else if (wr_idx == K_AREF) begin
            allow = !sref_on && !pwd_on;
        end else if (wr_idx == K_PWD) begin
            allow = !mode.acc && mode.aref && !sref_on && !dpd_on;
        end else if (wr_idx == K_DPD) begin
            allow = !mode.acc && !mode.aref && !sref_on && !pwd_on;
        end else if (wr_idx >= K_ADDR0 && wr_idx < K_TIM0) begin
            allow = all_quiet;
        end else if (wr_idx >= K_TIM0 && wr_idx < K_INIT0) begin
            allow = sref_on || (!mode.aref && !mode.acc);
        end else if (wr_idx == K_INIT0) begin
            allow = !mode.init_started;
        end else if (wr_idx == K_INIT1) begin
            allow = mode.init1_open;
        end
    end
endmodule

// File: rtl/sdg_state.sv
module sdg_state
    import sdg_pkg::*;
#(
    parameter int IDX_W = SDG_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_bits,
    output mode_t            mode
);
    localparam logic [IDX_W-1:0] K_ACC   = IDX_W'(IX_ACC);
    localparam logic [IDX_W-1:0] K_SREF  = IDX_W'(IX_SREF);
    localparam logic [IDX_W-1:0] K_AREF  = IDX_W'(IX_AREF);
    localparam logic [IDX_W-1:0] K_PWD   = IDX_W'(IX_PWD);
    localparam logic [IDX_W-1:0] K_DPD   = IDX_W'(IX_DPD);
    localparam logic [IDX_W-1:0] K_INIT0 = IDX_W'(IX_INIT0);

    localparam mode_t MODE_RST = '{acc: 1'b0, aref: 1'b0, sref: 2'b00, pwd: 2'b00,
                                   dpd: 2'b00, init_started: 1'b0, init1_open: 1'b1};

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (commit) begin
            if (wr_idx == K_ACC)  mode_d.acc  = wr_bits[0];
            if (wr_idx == K_AREF) mode_d.aref = wr_bits[0];
            if (wr_idx == K_SREF) mode_d.sref = wr_bits;
            if (wr_idx == K_PWD)  mode_d.pwd  = wr_bits;
            if (wr_idx == K_DPD) begin
                mode_d.dpd = wr_bits;
                if ((|mode_q.dpd) && !(|wr_bits)) begin
                    mode_d.init_started = 1'b0;
                    mode_d.init1_open   = 1'b1;
                end else if (!(|mode_q.dpd) && (|wr_bits)) begin
                    mode_d.init1_open   = 1'b0;
                end
            end
            if (wr_idx == K_INIT0 && wr_bits[0]) mode_d.init_started = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_RST;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;

    // R4
    sref_pwd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((|mode_q.sref) && (|mode_q.pwd)));

    // R9
    dpd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|mode_q.dpd) |-> (mode_q.init1_open && !mode_q.init_started));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(mode_q));
endmodule

// File: rtl/sdg_regfile.sv
module sdg_regfile
    import sdg_pkg::*;
#(
    parameter int IDX_W  = SDG_IDX_W,
    parameter int DATA_W = SDG_DATA_W,
    parameter int NAREA  = SDG_NAREA
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NAREA-1:0][DATA_W-1:0]  addr_regs,
    output logic [NAREA-1:0][DATA_W-1:0]  tim_regs,
    output logic [DATA_W-1:0]             init0_reg,
    output logic [DATA_W-1:0]             init1_reg
);
    localparam logic [IDX_W-1:0] K_INIT0 = IDX_W'(IX_INIT0);
    localparam logic [IDX_W-1:0] K_INIT1 = IDX_W'(IX_INIT1);

    typedef struct packed {
        logic [NAREA-1:0][DATA_W-1:0] addr;
        logic [NAREA-1:0][DATA_W-1:0] tim;
        logic [DATA_W-1:0]            init0;
        logic [DATA_W-1:0]            init1;
    } rf_t;

    rf_t rf_d, rf_q;
    logic [NAREA-1:0] addr_sel, tim_sel;

    for (genvar g = 0; g < NAREA; g++) begin : g_area
        assign addr_sel[g] = commit && (wr_idx == IDX_W'(IX_ADDR0 + g));
        assign tim_sel[g]  = commit && (wr_idx == IDX_W'(IX_TIM0 + g));
    end

    always_comb begin
        rf_d = rf_q;
        for (int a = 0; a < NAREA; a++) begin
            if (addr_sel[a]) rf_d.addr[a] = wr_data;
            if (tim_sel[a])  rf_d.tim[a]  = wr_data;
        end
        if (commit && wr_idx == K_INIT0) rf_d.init0 = wr_data;
        if (commit && wr_idx == K_INIT1) rf_d.init1 = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign addr_regs = rf_q.addr;
    assign tim_regs  = rf_q.tim;
    assign init0_reg = rf_q.init0;
    assign init1_reg = rf_q.init1;

    // R10
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(rf_q));
endmodule

// File: rtl/sdg_errlog.sv
module sdg_errlog
    import sdg_pkg::*;
#(
    parameter int IDX_W = SDG_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reject,
    input  logic             clear,
    input  logic [IDX_W-1:0] wr_idx,
    output logic             err_flag,
    output logic [IDX_W-1:0] err_idx
);
    typedef struct packed {
        logic             flag;
        logic [IDX_W-1:0] idx;
    } err_t;

    err_t err_d, err_q;

    always_comb begin
        err_d = err_q;
        if (reject) begin
            err_d.flag = 1'b1;
            err_d.idx  = wr_idx;
        end else if (clear) begin
            err_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign err_flag = err_q.flag;
    assign err_idx  = err_q.idx;

    // R10
    rej_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (err_flag && err_idx == $past(wr_idx)));

    // R11
    err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !reject) |=> !err_flag);
endmodule

// File: rtl/sdram_cfg_guard.sv
module sdram_cfg_guard
    import sdg_pkg::*;
#(
    parameter int DATA_W = SDG_DATA_W,
    parameter int NAREA  = SDG_NAREA,
    parameter int IDX_W  = SDG_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ok,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_flag,
    output logic [IDX_W-1:0]  err_idx,
    output logic              acc_on,
    output logic              aref_on,
    output logic              sref_on,
    output logic              pwd_on,
    output logic              dpd_on,
    output logic              init_started,
    output logic              init1_open
);
    localparam logic [IDX_W-1:0] K_ACC   = IDX_W'(IX_ACC);
    localparam logic [IDX_W-1:0] K_SREF  = IDX_W'(IX_SREF);
    localparam logic [IDX_W-1:0] K_AREF  = IDX_W'(IX_AREF);
    localparam logic [IDX_W-1:0] K_PWD   = IDX_W'(IX_PWD);
    localparam logic [IDX_W-1:0] K_DPD   = IDX_W'(IX_DPD);
    localparam logic [IDX_W-1:0] K_INIT0 = IDX_W'(IX_INIT0);
    localparam logic [IDX_W-1:0] K_INIT1 = IDX_W'(IX_INIT1);
    localparam logic [IDX_W-1:0] K_ERR   = IDX_W'(IX_ERR);

    mode_t mode;
    logic  allow, commit, reject, err_clear;
    logic [NAREA-1:0][DATA_W-1:0] addr_regs, tim_regs;
    logic [DATA_W-1:0] init0_reg, init1_reg;

    sdg_rules #(.IDX_W(IDX_W)) u_rules (
        .wr_idx (wr_idx),
        .mode   (mode),
        .allow  (allow)
    );

    assign commit    = wr_en && allow;
    assign reject    = wr_en && !allow;
    assign err_clear = commit && (wr_idx == K_ERR) && wr_data[0];
    assign wr_ok     = commit;

    sdg_state #(.IDX_W(IDX_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .wr_idx  (wr_idx),
        .wr_bits (wr_data[1:0]),
        .mode    (mode)
    );

    sdg_regfile #(.IDX_W(IDX_W), .DATA_W(DATA_W), .NAREA(NAREA)) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .addr_regs (addr_regs),
        .tim_regs  (tim_regs),
        .init0_reg (init0_reg),
        .init1_reg (init1_reg)
    );

    sdg_errlog #(.IDX_W(IDX_W)) u_errlog (
        .clk      (clk),
        .rst_n    (rst_n),
        .reject   (reject),
        .clear    (err_clear),
        .wr_idx   (wr_idx),
        .err_flag (err_flag),
        .err_idx  (err_idx)
    );

    always_comb begin
        rd_data = '0;
        if (rd_idx == K_ACC)   rd_data[0]   = mode.acc;
        if (rd_idx == K_AREF)  rd_data[0]   = mode.aref;
        if (rd_idx == K_SREF)  rd_data[1:0] = mode.sref;
        if (rd_idx == K_PWD)   rd_data[1:0] = mode.pwd;
        if (rd_idx == K_DPD)   rd_data[1:0] = mode.dpd;
        for (int a = 0; a < NAREA; a++) begin
            if (rd_idx == IDX_W'(IX_ADDR0 + a)) rd_data = addr_regs[a];
            if (rd_idx == IDX_W'(IX_TIM0 + a))  rd_data = tim_regs[a];
        end
        if (rd_idx == K_INIT0) rd_data = init0_reg;
        if (rd_idx == K_INIT1) rd_data = init1_reg;
        if (rd_idx == K_ERR) begin
            rd_data[0]        = err_flag;
            rd_data[4 +: IDX_W] = err_idx;
        end
    end

    assign acc_on       = mode.acc;
    assign aref_on      = mode.aref;
    assign sref_on      = |mode.sref;
    assign pwd_on       = |mode.pwd;
    assign dpd_on       = |mode.dpd;
    assign init_started = mode.init_started;
    assign init1_open   = mode.init1_open;
endmodule

// File: tb/sdram_cfg_guard_tb.sv
module sdram_cfg_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_idx = '0;
    logic        wr_ok, err_flag, acc_on, aref_on, sref_on, pwd_on, dpd_on;
    logic        init_started, init1_open;
    logic [31:0] rd_data;
    logic [3:0]  err_idx;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cfg_guard u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_ok(wr_ok), .rd_idx(rd_idx), .rd_data(rd_data), .err_flag(err_flag),
        .err_idx(err_idx), .acc_on(acc_on), .aref_on(aref_on), .sref_on(sref_on),
        .pwd_on(pwd_on), .dpd_on(dpd_on), .init_started(init_started),
        .init1_open(init1_open)
    );

    // {requirement number, index, data, expected accept}
    localparam logic [40:0] VEC [NV] = '{
        {4'd5,  4'd4,  32'h1,      1'b1},  // R5 enter deep-power-down
        {4'd9,  4'd10, 32'hA,      1'b0},  // R9 window closed
        {4'd2,  4'd1,  32'h1,      1'b0},  // R2 deep-power-down on
        {4'd5,  4'd4,  32'h0,      1'b1},  // R5 exit
        {4'd9,  4'd10, 32'h5,      1'b1},  // R9 reopened
        {4'd6,  4'd5,  32'h1234,   1'b1},  // R6 all off
        {4'd7,  4'd7,  32'hAB,     1'b1},  // R7 all off
        {4'd3,  4'd2,  32'h1,      1'b1},  // R3 auto-refresh on
        {4'd6,  4'd5,  32'hDEAD,   1'b0},  // R6 auto-refresh on
        {4'd7,  4'd7,  32'hEE,     1'b0},  // R7 auto-refresh on
        {4'd5,  4'd4,  32'h1,      1'b0},  // R5 auto-refresh on
        {4'd4,  4'd3,  32'h2,      1'b1},  // R4 power-down via bit 1
        {4'd2,  4'd1,  32'h1,      1'b0},  // R2 power-down on
        {4'd3,  4'd2,  32'h0,      1'b0},  // R3 power-down on
        {4'd4,  4'd3,  32'h0,      1'b1},  // R4 leave power-down
        {4'd2,  4'd1,  32'h2,      1'b1},  // R2 self-refresh via bit 1
        {4'd7,  4'd8,  32'h77,     1'b1},  // R7 self-refresh in progress
        {4'd4,  4'd3,  32'h1,      1'b0},  // R4 self-refresh on
        {4'd3,  4'd2,  32'h0,      1'b0},  // R3 self-refresh on
        {4'd2,  4'd1,  32'h0,      1'b1},  // R2 leave self-refresh
        {4'd1,  4'd0,  32'h1,      1'b1},  // R1 access always writable
        {4'd2,  4'd1,  32'h1,      1'b0},  // R2 access on
        {4'd4,  4'd3,  32'h1,      1'b0},  // R4 access on
        {4'd7,  4'd8,  32'h99,     1'b0},  // R7 access and auto-refresh on
        {4'd1,  4'd0,  32'h0,      1'b1},  // R1 access off
        {4'd8,  4'd9,  32'h1,      1'b1},  // R8 launch initialization
        {4'd8,  4'd9,  32'h1,      1'b0},  // R8 already started
        {4'd9,  4'd10, 32'h6,      1'b1},  // R9 window still open
        {4'd10, 4'd13, 32'h0,      1'b0},  // R10 undefined index
        {4'd11, 4'd11, 32'h1,      1'b1}   // R11 clear error
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] i, input logic [31:0] d, input logic exp,
                      input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_data = d;
        #(CLK_PERIOD/4);
        chk({31'd0, wr_ok}, {31'd0, exp}, tag);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        if (!exp) begin
            chk({31'd0, err_flag}, 32'd1, {tag, " err_flag"});
            chk({28'd0, err_idx}, {28'd0, i}, {tag, " err_idx"});
        end
    endtask

    task automatic rd(input logic [3:0] i, input logic [31:0] exp, input string tag);
        rd_idx = i;
        #1;
        chk(rd_data, exp, tag);
    endtask

    task automatic check_reset(input string tag);
        for (int i = 0; i < 11; i++) rd(4'(i), 32'h0, {tag, " R12 reg"});
        chk({25'd0, err_flag, acc_on, aref_on, sref_on, pwd_on, dpd_on, init_started},
            32'd0, {tag, " R12 flags"});
        chk({31'd0, init1_open}, 32'd1, {tag, " R12 window"});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset("start");
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            wr(VEC[v][36:33], VEC[v][32:1], VEC[v][0],
               $sformatf("R%0d vec%0d", VEC[v][40:37], v));
        end

        // R11 cleared flag, index kept
        rd(4'd11, 32'h000000D0, "R11 readback after clear");
        // R10 refused writes left stored data intact
        rd(4'd5, 32'h1234, "R10 addr0 kept");
        rd(4'd7, 32'hAB, "R10 tim0 kept");
        rd(4'd8, 32'h77, "R7 tim1");
        rd(4'd10, 32'h6, "R9 init1 data");
        chk({29'd0, aref_on, init_started, init1_open}, 32'h7, "R8 mode after table");

        // R1 alternative bit of deep-power-down, R9 window around it
        wr(4'd2, 32'h0, 1'b1, "R3 auto-refresh off");
        wr(4'd4, 32'h2, 1'b1, "R5 enter via bit 1");
        chk({30'd0, dpd_on, init1_open}, 32'h2, "R1 dpd bit1 / R9 window closed");
        rd(4'd4, 32'h2, "R1 dpd readback");
        wr(4'd10, 32'hF, 1'b0, "R9 refused in dpd");
        rd(4'd10, 32'h6, "R10 init1 unchanged");
        wr(4'd4, 32'h0, 1'b1, "R5 exit");
        chk({30'd0, init_started, init1_open}, 32'h1, "R9 exit re-arms");
        wr(4'd9, 32'h0, 1'b1, "R8 write without launch");
        chk({31'd0, init_started}, 32'd0, "R8 bit0 clear keeps not started");

        // R12 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset("mid");
        @(negedge clk);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule